// File: doc/BRIEF.md
# Three-Tap FIR Filter with Cutset Pipelining

This block is a direct-form finite impulse response filter with three taps. Each accepted sample x(n) produces y(n) = a·x(n) + b·x(n−1) + c·x(n−2) in two's-complement fixed point, with no rounding or saturation. Here x(n−1) and x(n−2) are the two samples accepted before x(n). It accepts one sample per clock whenever `in_valid` is high. Cycles with `in_valid` low are bubbles that leave the sample history untouched.

An optional register stage lies on a feed-forward cutset that separates the b and c partial sum from the final adder. The same cutset also crosses the path of the newest sample into its multiplier. Every edge that crosses the cutset gets exactly one register. The longest combinational path therefore shrinks from one multiply and two adds to one multiply and one add, and the result arrives one clock later. The three coefficients are loaded through a strobe. The strobe takes effect only when no sample is entering or in flight, so a result is never computed from a mix of old and new coefficients.

Top module: `fir3_cutset_pipe`

## Requirements
- R1: For each accepted sample, `out_data` equals a·x(n) + b·x(n−1) + c·x(n−2) as a signed 34-bit two's-complement value. a, b and c are the loaded `coef_a`, `coef_b` and `coef_c`, and all samples and coefficients are signed 16-bit.
- R2: With the cutset stage enabled (default), `out_valid` is high exactly in the cycle two clocks after the edge that accepted the sample. No other cycle has `out_valid` high.
- R3: A cycle with `in_valid` low does not advance the sample history, so x(n−1) and x(n−2) are always the previous accepted samples, whatever the gaps between them.
- R4: While `out_valid` is low, `out_data` keeps the last result.
- R5: When `coef_load` is high at an edge where `in_valid` is low and no sample is in flight, all three coefficients are replaced and apply to every sample accepted afterwards.
- R6: `coef_load` has no effect at an edge where `in_valid` is high or a sample accepted at the previous edge is still in flight.
- R7: Synchronous reset clears the sample history, the coefficients, the pipeline registers and `out_data` to zero, and deasserts `out_valid`. The first samples after reset see zero history.
- R8: The extreme operands (−32768 for every sample and coefficient) produce the exact sum 3221225472 with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| coef_load | input | 1 | Coefficient load strobe, honoured only when idle |
| coef_a | input | 16 | Signed weight of the newest sample |
| coef_b | input | 16 | Signed weight of the previous sample |
| coef_c | input | 16 | Signed weight of the sample before that |
| out_valid | output | 1 | Result strobe |
| out_data | output | 34 | Signed full-precision result |

## Verification
The bench sweeps every combination of the extreme and unit coefficient values against streams that mix extreme and pseudo-random samples with irregular bubbles. A design that shifted the history on bubbles, or paired the registered partial sum with the wrong newest sample, would give wrong sums at a gap. A valid strobe that skips the cutset register would fire a cycle early. Loads are attempted on the same edge as a sample and on the edge right after one. A bank that ignored in-flight samples would mix coefficient sets inside one result. A reset in the middle of a stream must leave zero history, so stale taps would show up in the first results after reset.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

   // number of taps handled by the filter core
   localparam int unsigned FIR3_TAPS = 3;

   // clocks from sample acceptance to result strobe
   function automatic int unsigned fir3_latency(input bit cut_en);
      return cut_en ? 2 : 1;
   endfunction

   // guard bits needed so that a sum of n full products cannot wrap
   function automatic int unsigned fir3_guard_bits(input int unsigned n);
      return $clog2(n);
   endfunction

endpackage

// File: rtl/fir3_coef_bank.sv
module fir3_coef_bank #(
   parameter int unsigned COEF_W = 16,
   parameter int unsigned TAPS   = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          load,
   input  logic                          busy,
   input  logic [TAPS-1:0][COEF_W-1:0]   coef_d,
   output logic [TAPS-1:0][COEF_W-1:0]   coef_q
);

   logic take;
   assign take = load & ~busy;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [COEF_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            w_q <= '0;
         end else if (take) begin
            w_q <= coef_d[t];
         end
      end
      assign coef_q[t] = w_q;
   end

   // R6: weights never move while a sample enters or is in flight
   a_r6_coef_frozen: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(coef_q));

   // R5: an idle load replaces every weight
   a_r5_idle_take: assert property (@(posedge clk) disable iff (rst)
      (load && !busy) |=> (coef_q == $past(coef_d)));

endmodule

// File: rtl/fir3_tapline.sv
module fir3_tapline #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          shift,
   input  logic [DATA_W-1:0]             din,
   output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      logic [DATA_W-1:0] h_q;
      logic [DATA_W-1:0] h_d;
      if (k == 0) begin : g_head
         assign h_d = din;
      end else begin : g_body
         assign h_d = taps[k-1];
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            h_q <= '0;
         end else if (shift) begin
            h_q <= h_d;
         end
      end
      assign taps[k] = h_q;
   end

   // R1: the newest history slot receives the accepted sample
   a_r1_newest_tap: assert property (@(posedge clk) disable iff (rst)
      shift |=> (taps[0] == $past(din)));

   // R3: a bubble leaves the whole history untouched
   a_r3_tap_hold: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(taps));

endmodule

// File: rtl/fir3_cut_stage.sv
module fir3_cut_stage #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned ACC_W  = 34,
   parameter bit          CUT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_vld,
   input  logic [DATA_W-1:0]  x_now,
   input  logic [DATA_W-1:0]  x_prev1,
   input  logic [DATA_W-1:0]  x_prev2,
   input  logic [COEF_W-1:0]  w_now,
   input  logic [COEF_W-1:0]  w_prev1,
   input  logic [COEF_W-1:0]  w_prev2,
   output logic               out_vld,
   output logic [ACC_W-1:0]   out_acc,
   output logic               busy
);

   localparam int unsigned PROD_W = DATA_W + COEF_W;
   localparam int unsigned PART_W = PROD_W + 1;

   function automatic logic signed [PROD_W-1:0] smul(
      input logic [DATA_W-1:0] x,
      input logic [COEF_W-1:0] w
   );
      return PROD_W'($signed(x)) * PROD_W'($signed(w));
   endfunction

   // older two taps: one multiply level and one add
   logic signed [PROD_W-1:0] prod_p1;
   logic signed [PROD_W-1:0] prod_p2;
   logic signed [PART_W-1:0] part_c;

   always_comb begin
      prod_p1 = smul(x_prev1, w_prev1);
      prod_p2 = smul(x_prev2, w_prev2);
      part_c  = PART_W'(prod_p1) + PART_W'(prod_p2);
   end

   if (CUT_EN) begin : g_cut
      // cutset registers: partial sum and newest sample, one each
      logic signed [PART_W-1:0] part_q;
      logic [DATA_W-1:0]        xnow_q;
      logic                     mid_vld_q;
      logic [ACC_W-1:0]         acc_q;
      logic                     vld_q;
      logic signed [PROD_W-1:0] prod_now;

      always_comb begin
         prod_now = smul(xnow_q, w_now);
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            part_q    <= '0;
            xnow_q    <= '0;
            mid_vld_q <= 1'b0;
            acc_q     <= '0;
            vld_q     <= 1'b0;
         end else begin
            mid_vld_q <= in_vld;
            if (in_vld) begin
               part_q <= part_c;
               xnow_q <= x_now;
            end
            vld_q <= mid_vld_q;
            if (mid_vld_q) begin
               acc_q <= ACC_W'(part_q) + ACC_W'(prod_now);
            end
         end
      end

      assign out_vld = vld_q;
      assign out_acc = acc_q;
      assign busy    = mid_vld_q;
   end else begin : g_direct
      logic [ACC_W-1:0]         acc_q;
      logic                     vld_q;
      logic signed [PROD_W-1:0] prod_now;

      always_comb begin
         prod_now = smul(x_now, w_now);
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            acc_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= in_vld;
            if (in_vld) begin
               acc_q <= ACC_W'(part_c) + ACC_W'(prod_now);
            end
         end
      end

      assign out_vld = vld_q;
      assign out_acc = acc_q;
      assign busy    = 1'b0;
   end

endmodule

// File: rtl/fir3_cutset_pipe.sv
module fir3_cutset_pipe
   import fir3_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned ACC_W  = 34,
   parameter bit          CUT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_sample,
   input  logic               coef_load,
   input  logic [COEF_W-1:0]  coef_a,
   input  logic [COEF_W-1:0]  coef_b,
   input  logic [COEF_W-1:0]  coef_c,
   output logic               out_valid,
   output logic [ACC_W-1:0]   out_data
);

   localparam int unsigned TAPS    = FIR3_TAPS;
   localparam int unsigned HIST    = TAPS - 1;
   localparam int unsigned MIN_ACC = DATA_W + COEF_W + fir3_guard_bits(TAPS);
   localparam int unsigned LAT     = fir3_latency(CUT_EN);

   if (ACC_W < MIN_ACC) begin : g_bad_acc
      $error("fir3_cutset_pipe: ACC_W too narrow for full-precision sum");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_w
      $error("fir3_cutset_pipe: sample and weight widths must be at least 2");
   end
   if (LAT < 1 || LAT > 2) begin : g_bad_lat
      $error("fir3_cutset_pipe: unsupported pipeline depth");
   end

   logic [HIST-1:0][DATA_W-1:0] hist;
   logic [TAPS-1:0][COEF_W-1:0] w_d;
   logic [TAPS-1:0][COEF_W-1:0] w_q;
   logic                        core_busy;
   logic                        busy;

   assign w_d  = {coef_c, coef_b, coef_a};
   assign busy = in_valid | core_busy;

   fir3_coef_bank #(
      .COEF_W (COEF_W),
      .TAPS   (TAPS)
   ) u_coef (
      .clk    (clk),
      .rst    (rst),
      .load   (coef_load),
      .busy   (busy),
      .coef_d (w_d),
      .coef_q (w_q)
   );

   fir3_tapline #(
      .DATA_W (DATA_W),
      .DEPTH  (HIST)
   ) u_hist (
      .clk    (clk),
      .rst    (rst),
      .shift  (in_valid),
      .din    (in_sample),
      .taps   (hist)
   );

   fir3_cut_stage #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W),
      .CUT_EN (CUT_EN)
   ) u_core (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (in_valid),
      .x_now   (in_sample),
      .x_prev1 (hist[0]),
      .x_prev2 (hist[1]),
      .w_now   (w_q[0]),
      .w_prev1 (w_q[1]),
      .w_prev2 (w_q[2]),
      .out_vld (out_valid),
      .out_acc (out_data),
      .busy    (core_busy)
   );

   if (CUT_EN) begin : g_chk_cut
      // R2: strobe lags the accepted sample by two clocks
      a_r2_valid_lag: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> ##1 out_valid);
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> ##1 !out_valid);
   end else begin : g_chk_direct
      a_r2_valid_lag: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
   end

   // R4: result held across cycles without a strobe
   a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_valid || $stable(out_data)));

   // R7: reset clears the result port
   a_r7_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/fir3_cutset_pipe_bench.sv
`timescale 1ns/1ps
module fir3_cutset_pipe_bench;

   localparam int DW  = 16;
   localparam int CW  = 16;
   localparam int AW  = 34;
   localparam int LAT = 2;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_sample = '0;
   logic                 coef_load = 1'b0;
   logic signed [CW-1:0] coef_a = '0;
   logic signed [CW-1:0] coef_b = '0;
   logic signed [CW-1:0] coef_c = '0;
   logic                 out_valid;
   logic signed [AW-1:0] out_data;

   fir3_cutset_pipe u_fir3_cutset_pipe (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .coef_load (coef_load),
      .coef_a    (coef_a),
      .coef_b    (coef_b),
      .coef_c    (coef_c),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int     n_chk = 0;
   int     n_bad = 0;
   bit     done  = 1'b0;
   longint m_a = 0, m_b = 0, m_c = 0;
   longint h1 = 0, h2 = 0;
   longint exp_q[$];
   int     due_q[$];
   longint last_out = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic report(input string req, input longint act, input longint expv);
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
   endtask

   // output monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
               report("R2 unexpected strobe", 1, 0);
            end else begin
               longint e;
               int     d;
               e = exp_q.pop_front();
               d = due_q.pop_front();
               if (longint'(out_data) != e) report("R1 result", longint'(out_data), e);
               n_chk++;
               if (cyc != d) report("R2 strobe cycle", cyc, d);
            end
            last_out = longint'(out_data);
         end else begin
            n_chk++;
            if (longint'(out_data) != last_out) report("R4 hold", longint'(out_data), last_out);
         end
      end
   end

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
   endfunction

   task automatic send(input logic signed [DW-1:0] x);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = x;
      coef_load = 1'b0;
      exp_q.push_back(m_a * longint'(x) + m_b * h1 + m_c * h2);
      due_q.push_back(cyc + LAT);
      h2 = h1;
      h1 = longint'(x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         coef_load = 1'b0;
      end
   endtask

   task automatic load_coef(input logic signed [CW-1:0] a, input logic signed [CW-1:0] b,
                            input logic signed [CW-1:0] c, input bit take);
      @(negedge clk);
      in_valid  = 1'b0;
      coef_load = 1'b1;
      coef_a = a; coef_b = b; coef_c = c;
      if (take) begin
         m_a = longint'(a); m_b = longint'(b); m_c = longint'(c);
      end
   endtask

   // R6: load strobe on the same edge as a sample, ignored
   task automatic send_and_load(input logic signed [DW-1:0] x, input logic signed [CW-1:0] a);
      send(x);
      coef_load = 1'b1;
      coef_a = a; coef_b = a; coef_c = a;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; coef_load = 1'b0;
      @(negedge clk);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) report("R7 reset strobe", out_valid, 0);
      n_chk++;
      if (longint'(out_data) != 0) report("R7 reset data", longint'(out_data), 0);
      exp_q.delete(); due_q.delete();
      h1 = 0; h2 = 0; m_a = 0; m_b = 0; m_c = 0; last_out = 0;
      rst = 1'b0;
   endtask

   task automatic rand_stream(input int n);
      for (int i = 0; i < n; i++) begin
         logic signed [DW-1:0] x;
         lfsr = lfsr_next(lfsr);
         case (lfsr[2:0])
            3'd0:    x = -16'sd32768;
            3'd1:    x = 16'sd32767;
            3'd2:    x = -16'sd1;
            default: x = $signed(lfsr);
         endcase
         send(x);
         lfsr = lfsr_next(lfsr);
         if (lfsr[1:0] == 2'd0) idle(1 + int'(lfsr[3:2]));  // R3 bubbles
      end
   endtask

   initial begin
      logic signed [CW-1:0] vals [5];
      vals[0] = -16'sd32768; vals[1] = -16'sd1; vals[2] = 16'sd0;
      vals[3] = 16'sd1;      vals[4] = 16'sd32767;

      do_reset();                               // R7 initial state

      // zero weights after reset: results are zero
      rand_stream(3);
      idle(3);

      // R8 extreme operands
      load_coef(-16'sd32768, -16'sd32768, -16'sd32768, 1'b1);
      idle(1);
      send(-16'sd32768); send(-16'sd32768); send(-16'sd32768);
      idle(3);

      // R1/R3/R5 sweep over every weight combination
      for (int ia = 0; ia < 5; ia++)
         for (int ib = 0; ib < 5; ib++)
            for (int ic = 0; ic < 5; ic++) begin
               idle(2);
               load_coef(vals[ia], vals[ib], vals[ic], 1'b1);   // R5
               rand_stream(6);
            end
      idle(3);

      // R6: load on a sample edge, then on the edge after a sample
      load_coef(16'sd3, -16'sd5, 16'sd7, 1'b1);
      idle(1);
      send(16'sd100);
      send_and_load(16'sd200, 16'sd999);
      send(-16'sd300);
      load_coef(16'sd11, 16'sd11, 16'sd11, 1'b0);   // sample in flight
      idle(1);
      send(16'sd400);
      send(16'sd500);
      idle(3);

      // R7: reset mid-history, first results see zero history
      send(16'sd1234);
      send(-16'sd4321);
      idle(3);
      do_reset();
      idle(1);
      load_coef(16'sd2, 16'sd3, 16'sd4, 1'b1);
      idle(1);
      send(16'sd10); send(16'sd20); send(16'sd30);
      idle(4);

      n_chk++;
      if (exp_q.size() != 0) report("R2 missing results", 0, exp_q.size());

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         report("watchdog", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule